// File: doc/BRIEF.md
# Host-Bus RAM Bridge with USB Arbitration

This block connects an external host processor to an internal shared RAM through a one-byte transfer buffer. The host drives active-low chip-select, read and write strobes that are asynchronous to the internal clock. The block synchronizes these strobes and reacts only to the trailing (rising) edge of a read or write strobe. After that edge it moves the byte between the buffer and the RAM. For a write, the byte the host presented is stored. For a read, the buffer is refilled ahead of time, so the next read strobe finds its byte already waiting.

A USB engine shares the same single RAM port and always wins it. A host transfer that is waiting simply stalls while the USB request lasts. An address pointer selects the RAM location. The pointer can be loaded directly, and in burst mode it steps by one after every completed host transfer. A busy output covers each internal transfer. A sticky overrun flag records any host edge that was dropped because it arrived while the block was busy.

Top module: `hostRamBridge`

## Requirements
- R1: Strobes pass through a two-stage synchronizer, and a transfer starts only on the synchronized rising (trailing) edge of read or write. Holding a strobe low never starts a transfer.
- R2: A read or write edge counts only while chip-select (active low) is asserted. A strobe with chip-select high leaves the RAM, busy and overrun unchanged.
- R3: On a write edge, the byte on hostDataIn during the strobe's low phase is written to RAM at the current pointer.
- R4: On a read edge, the buffer (hostDataOut) is refilled from the RAM. The address is pointer+1 in burst mode and the pointer itself otherwise.
- R5: A one-cycle ptrLoad pulse while idle sets the pointer to ptrLoadVal and fills the buffer with RAM[ptrLoadVal].
- R6: With burstMode=1, the pointer increments by one after each completed host read or write.
- R7: With burstMode=0, the pointer does not move, so repeated reads return the same location.
- R8: With usbReq low, busy is high for exactly two clock cycles per host transfer.
- R9: usbReq wins the RAM port in the same cycle (usbGrant=1, and the RAM is driven from the usb* inputs). A pending host transfer waits, and busy stretches by one cycle for each USB cycle. A wait of at most two cycles follows when USB requests last at most two cycles.
- R10: With USB idle, host edges spaced three clocks apart are all accepted, without overrun.
- R11: A host edge that arrives while busy is dropped and sets overrun. Overrun stays set until reset.
- R12: After reset, busy=0, overrun=0 and hostDataOut=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCsN | input | 1 | Host chip-select, active low, asynchronous |
| hostRdN | input | 1 | Host read strobe, active low, asynchronous |
| hostWrN | input | 1 | Host write strobe, active low, asynchronous |
| hostDataIn | input | DATA_W | Host write data |
| hostDataOut | output | DATA_W | Transfer buffer contents for host reads |
| ptrLoad | input | 1 | Load the pointer and refill the buffer |
| ptrLoadVal | input | ADDR_W | Pointer load value |
| burstMode | input | 1 | 1: pointer steps after each transfer |
| busy | output | 1 | Internal transfer in progress |
| overrun | output | 1 | Sticky flag for a dropped host edge |
| usbReq | input | 1 | USB RAM request |
| usbWe | input | 1 | USB write enable |
| usbAddr | input | ADDR_W | USB RAM address |
| usbWdata | input | DATA_W | USB write data |
| usbGrant | output | 1 | USB owns the RAM port this cycle |
| ramEn | output | 1 | RAM access enable |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | ADDR_W | RAM address |
| ramWdata | output | DATA_W | RAM write data |
| ramRdata | input | DATA_W | RAM read data, one cycle after ramEn |

## Verification
The wait-bound assertion relies on the USB engine never holding usbReq for more than two consecutive cycles. The other checks rely on burstMode staying constant during a transfer and on ptrLoad being pulsed only while busy is low. The directed stimulus keeps every USB request to two cycles or fewer, changes burstMode and ptrLoad only after a transfer has settled, and holds hostDataIn steady across the whole write strobe. Host edges come too close together only in the overrun scenario, where that is the point of the test.

// File: rtl/bridgePkg.sv
package bridgePkg;
  typedef enum logic [1:0] {OP_RD, OP_WR, OP_LD} opKind_t;
  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_DONE} busState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchWr;   // copy synchronized host data into buffer
    logic loadPtr;   // load pointer from ptrLoadVal
    logic ramGo;     // host-side RAM access this cycle
    logic ramWrite;  // that access is a write
    logic addrNext;  // address pointer+1 instead of pointer
    logic capture;   // take RAM read data into buffer
    logic ptrStep;   // advance pointer
  } bridgeStrobes_t;
endpackage

// File: rtl/strobeSync.sv
module strobeSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic rdN,
  input  logic wrN,
  output logic rdRise,
  output logic wrRise,
  output logic wrActive
);
  localparam int DEPTH = SYNC_STAGES + 1;
  localparam int NCH   = 3;  // 2: cs, 1: rd, 0: wr

  logic [NCH-1:0] rawIn;
  logic [NCH-1:0] settled;
  logic [NCH-1:0] delayed;

  assign rawIn = {csN, rdN, wrN};

  generate
    for (genvar c = 0; c < NCH; c++) begin : gCh
      logic [DEPTH-1:0] sh;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) sh <= '1;
        else       sh <= {sh[DEPTH-2:0], rawIn[c]};
      end
      assign settled[c] = sh[SYNC_STAGES-1];
      assign delayed[c] = sh[SYNC_STAGES];
    end
  endgenerate

  // Trailing edge of a strobe, qualified by chip-select held low
  assign rdRise   = settled[1] & ~delayed[1] & ~delayed[2];
  assign wrRise   = settled[0] & ~delayed[0] & ~delayed[2];
  assign wrActive = ~settled[0] & ~settled[2];

  // R1: an edge is a single-cycle event
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (rdRise || wrRise) |=> !(rdRise || wrRise));
endmodule

// File: rtl/bridgeCtrl.sv
module bridgeCtrl
  import bridgePkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           rdRise,
  input  logic           wrRise,
  input  logic           wrActive,
  input  logic           ptrLoad,
  input  logic           burstMode,
  input  logic           usbReq,
  output bridgeStrobes_t strb,
  output logic           busy,
  output logic           overrun
);
  localparam int WAIT_W = 3;

  busState_t         state;
  opKind_t           op;
  logic [WAIT_W-1:0] waitCnt;
  logic              hostEdge;

  assign hostEdge = rdRise | wrRise;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      op      <= OP_RD;
      overrun <= 1'b0;
      waitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (hostEdge) begin
            op    <= wrRise ? OP_WR : OP_RD;
            state <= ST_ACCESS;
          end else if (ptrLoad) begin
            op    <= OP_LD;
            state <= ST_ACCESS;
          end
        end
        ST_ACCESS: if (!usbReq) state <= ST_DONE;
        ST_DONE:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase

      if (hostEdge && busy) overrun <= 1'b1;

      if (state == ST_ACCESS && usbReq) begin
        if (waitCnt != '1) waitCnt <= waitCnt + 1'b1;
      end else begin
        waitCnt <= '0;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.latchWr  = wrActive && (state == ST_IDLE);
    strb.loadPtr  = ptrLoad && (state == ST_IDLE) && !hostEdge;
    strb.ramGo    = (state == ST_ACCESS) && !usbReq;
    strb.ramWrite = (op == OP_WR);
    strb.addrNext = burstMode && (op == OP_RD);
    strb.capture  = (state == ST_DONE) && (op != OP_WR);
    strb.ptrStep  = (state == ST_DONE) && burstMode && (op != OP_LD);
  end

  // R8: a transfer keeps busy for at least two cycles
  a_r8_min_two: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);
  // R11: overrun is sticky
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
  // R11: edge while busy raises overrun
  a_r11_set: assert property (@(posedge clk) disable iff (!rstN)
    (hostEdge && busy) |=> overrun);
  // R9: USB stall on a pending host access is bounded
  a_r9_wait_bound: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= 3'd2);
endmodule

// File: rtl/bridgeDatapath.sv
module bridgeDatapath
  import bridgePkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [ADDR_W-1:0] ptrLoadVal,
  input  bridgeStrobes_t    strb,
  input  logic              usbReq,
  input  logic              usbWe,
  input  logic [ADDR_W-1:0] usbAddr,
  input  logic [DATA_W-1:0] usbWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata
);
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] buffer;
  logic [ADDR_W-1:0] hostAddr;
  logic [DATA_W-1:0] dataSynced;

  // Data delayed to line up with the synchronized write strobe
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gStage
      logic [DATA_W-1:0] q;
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) q <= '0; else q <= hostDataIn;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) q <= '0; else q <= gStage[s-1].q;
      end
    end
  endgenerate
  assign dataSynced = gStage[SYNC_STAGES-1].q;

  assign hostAddr = strb.addrNext ? ptr + 1'b1 : ptr;

  always_comb begin
    if (usbReq) begin
      ramEn    = 1'b1;
      ramWe    = usbWe;
      ramAddr  = usbAddr;
      ramWdata = usbWdata;
    end else begin
      ramEn    = strb.ramGo;
      ramWe    = strb.ramGo && strb.ramWrite;
      ramAddr  = hostAddr;
      ramWdata = buffer;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr    <= '0;
      buffer <= '0;
    end else begin
      if (strb.capture)      buffer <= ramRdata;
      else if (strb.latchWr) buffer <= dataSynced;
      if (strb.loadPtr)      ptr <= ptrLoadVal;
      else if (strb.ptrStep) ptr <= ptr + 1'b1;
    end
  end

  assign hostDataOut = buffer;

  // R4: buffer refill always follows a host-owned RAM access
  a_r4_capture_after_access: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> $past(ramEn && !usbReq));
  // R9: control never launches a host access while USB holds the port
  a_r9_usb_owns: assert property (@(posedge clk) disable iff (!rstN)
    usbReq |-> !strb.ramGo);
endmodule

// File: rtl/hostRamBridge.sv
module hostRamBridge
  import bridgePkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  input  logic              ptrLoad,
  input  logic [ADDR_W-1:0] ptrLoadVal,
  input  logic              burstMode,
  output logic              busy,
  output logic              overrun,
  input  logic              usbReq,
  input  logic              usbWe,
  input  logic [ADDR_W-1:0] usbAddr,
  input  logic [DATA_W-1:0] usbWdata,
  output logic              usbGrant,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata
);
  logic           rdRise, wrRise, wrActive;
  bridgeStrobes_t strb;

  assign usbGrant = usbReq;

  strobeSync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .csN(hostCsN), .rdN(hostRdN), .wrN(hostWrN),
    .rdRise(rdRise), .wrRise(wrRise), .wrActive(wrActive)
  );

  bridgeCtrl uCtrl (
    .clk(clk), .rstN(rstN), .rdRise(rdRise), .wrRise(wrRise),
    .wrActive(wrActive), .ptrLoad(ptrLoad), .burstMode(burstMode),
    .usbReq(usbReq), .strb(strb), .busy(busy), .overrun(overrun)
  );

  bridgeDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk), .rstN(rstN), .hostDataIn(hostDataIn), .ptrLoadVal(ptrLoadVal),
    .strb(strb), .usbReq(usbReq), .usbWe(usbWe), .usbAddr(usbAddr),
    .usbWdata(usbWdata), .ramRdata(ramRdata), .hostDataOut(hostDataOut),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata)
  );
endmodule

// File: tb/hostRamBridge_test.sv
module hostRamBridge_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1;
  logic [7:0] hostDataIn = '0, hostDataOut;
  logic       ptrLoad = 1'b0;
  logic [7:0] ptrLoadVal = '0;
  logic       burstMode = 1'b1;
  logic       busy, overrun;
  logic       usbReq = 1'b0, usbWe = 1'b0;
  logic [7:0] usbAddr = '0, usbWdata = '0;
  logic       usbGrant, ramEn, ramWe;
  logic [7:0] ramAddr, ramWdata;
  logic [7:0] ramRdata = '0;
  logic [7:0] mem [256];
  int checks = 0, fails = 0, busyCnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hostRamBridge uut (.*);

  always @(posedge clk) if (ramEn) begin
    if (ramWe) mem[ramAddr] <= ramWdata;
    ramRdata <= mem[ramAddr];
  end

  always begin
    @(posedge clk); #5;
    if (busy) busyCnt++;
  end

  function automatic logic [7:0] seed(int a);
    return 8'((a * 7 + 3) & 8'hFF);
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; tick(3); rstN = 1'b1; tick(2);
  endtask

  task automatic loadPtr(logic [7:0] v);
    ptrLoadVal = v; ptrLoad = 1'b1; tick(1); ptrLoad = 1'b0; tick(6);
  endtask

  task automatic hostRead();
    hostCsN = 1'b0; tick(1);
    hostRdN = 1'b0; tick(2);
    hostRdN = 1'b1; tick(1);
    hostCsN = 1'b1; tick(6);
  endtask

  task automatic hostWrite(logic [7:0] d);
    hostCsN = 1'b0; tick(1);
    hostWrN = 1'b0; hostDataIn = d; tick(2);
    hostWrN = 1'b1; tick(1);
    hostCsN = 1'b1; tick(6);
  endtask

  task automatic testReset();
    check("R12 busy", busy, 0);
    check("R12 overrun", overrun, 0);
    check("R12 dataOut", hostDataOut, 0);
  endtask

  task automatic testLoad();
    burstMode = 1'b1;
    loadPtr(8'h10);
    check("R5 prefetch after load", hostDataOut, seed(8'h10));
  endtask

  task automatic testRiseAndBurst();
    hostCsN = 1'b0; tick(1);
    busyCnt = 0;
    hostRdN = 1'b0; tick(6);
    check("R1 no transfer while low", busyCnt, 0);
    hostRdN = 1'b1; tick(1); hostCsN = 1'b1; tick(6);
    check("R8 busy two cycles", busyCnt, 2);
    check("R4 burst prefetch next", hostDataOut, seed(8'h11));
    hostRead();
    check("R6 pointer stepped", hostDataOut, seed(8'h12));
  endtask

  task automatic testFixed();
    burstMode = 1'b0;
    loadPtr(8'h30);
    hostRead();
    check("R7 first read fixed", hostDataOut, seed(8'h30));
    hostRead();
    check("R7 second read fixed", hostDataOut, seed(8'h30));
    burstMode = 1'b1;
  endtask

  task automatic testWrite();
    burstMode = 1'b1;
    loadPtr(8'h40);
    hostWrite(8'h11); hostWrite(8'h22); hostWrite(8'h33);
    check("R3 write 0x40", mem[8'h40], 8'h11);
    check("R3 write 0x41", mem[8'h41], 8'h22);
    check("R3 write 0x42", mem[8'h42], 8'h33);
    check("R3 neighbour untouched", mem[8'h43], seed(8'h43));
  endtask

  task automatic testNoCs();
    busyCnt = 0;
    hostWrN = 1'b0; hostDataIn = 8'h77; tick(2);
    hostWrN = 1'b1; tick(2);
    hostRdN = 1'b0; tick(2);
    hostRdN = 1'b1; tick(6);
    check("R2 no busy without cs", busyCnt, 0);
    check("R2 ram untouched", mem[8'h43], seed(8'h43));
    check("R2 overrun unchanged", overrun, 0);
    hostWrite(8'h44);
    check("R2 pointer not moved", mem[8'h43], 8'h44);
  endtask

  task automatic testUsb();
    burstMode = 1'b1;
    loadPtr(8'h50);
    hostCsN = 1'b0; tick(1);
    hostRdN = 1'b0; tick(2);
    busyCnt = 0;
    hostRdN = 1'b1; tick(3);
    usbReq = 1'b1; usbWe = 1'b1; usbAddr = 8'h51; usbWdata = 8'h5A;
    #1 check("R9 grant", usbGrant, 1);
    check("R9 ram address from usb", ramAddr, 8'h51);
    tick(2);
    usbReq = 1'b0; usbWe = 1'b0; hostCsN = 1'b1;
    tick(6);
    check("R9 busy stretched", busyCnt, 4);
    check("R9 usb write done", mem[8'h51], 8'h5A);
    check("R9 host read after usb", hostDataOut, 8'h5A);
  endtask

  task automatic testSpacing();
    loadPtr(8'h60);
    busyCnt = 0;
    hostCsN = 1'b0; tick(1);
    hostRdN = 1'b0; tick(2);
    hostRdN = 1'b1; tick(1);
    hostRdN = 1'b0; tick(2);
    hostRdN = 1'b1; tick(1);
    hostCsN = 1'b1; tick(8);
    check("R10 no overrun", overrun, 0);
    check("R10 both accepted", hostDataOut, seed(8'h62));
    check("R10 busy total", busyCnt, 4);
  endtask

  task automatic testOverrun();
    loadPtr(8'h70);
    busyCnt = 0;
    hostCsN = 1'b0; tick(1);
    hostRdN = 1'b0; tick(2);
    hostRdN = 1'b1; tick(1);
    hostRdN = 1'b0; tick(1);
    hostRdN = 1'b1; tick(1);
    hostCsN = 1'b1; tick(8);
    check("R11 overrun set", overrun, 1);
    check("R11 second edge dropped", hostDataOut, seed(8'h71));
    check("R11 single transfer", busyCnt, 2);
    hostRead();
    check("R11 overrun sticky", overrun, 1);
    check("R11 later read normal", hostDataOut, seed(8'h72));
    doReset();
    check("R12 overrun cleared", overrun, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = seed(i);
    doReset();
    testReset();
    testLoad();
    testRiseAndBurst();
    testFixed();
    testWrite();
    testNoCs();
    testUsb();
    testSpacing();
    testOverrun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule